// File: doc/BRIEF.md
# Register-Configured Packet Data Generator

This block is a packet data source. It produces one 128-byte packet each time a request is accepted. A small 32-bit register bus sets it up. Software or a testbench turns the generator on and picks a byte coding mode. It can also load a 32-bit seed for a pseudo-random byte stream, or fill a 128-entry user byte memory. Once the block is configured, a pulse on the request input starts generation. Writing the trigger bit of the control register has the same effect.

The packet is built one byte per clock into a 1024-bit output vector, with byte i at bits `8*i+7 : 8*i`. While a packet is being built the ready flag is low. The flag rises in the same cycle that the last byte is stored. The output then holds its value until the next accepted request.

Requests that cannot be served set sticky bits in an error register. This happens when the generator is disabled, or when the mode is the unsupported file-load code or an undefined code. Such a request produces no packet.

Top module: `pktgen_top`

## Requirements
- R1: After reset, `pkt_ready` is 0, `pkt_data` is all zero, and the control (0x0), configuration (0x1), error (0x2) and seed (0x3) registers all read 0.
- R2: A read strobe with address A loads `reg_rdata` at that clock edge, and the value then holds. Control bit 0 is the enable bit. Configuration bits 3:0 are the mode. The seed register reads back all 32 bits. Addresses that are not mapped read 0.
- R3: Writing the control register with bit 1 set acts as one request in that cycle, exactly like a `gen_req` pulse. The request sees the enable bit as it was before the write. Control bit 1 always reads 0.
- R4: A request is accepted when the generator is enabled, idle, and the mode is 0, 1 or 3. `pkt_ready` goes low at the accepting edge and goes high at the 128th edge after it, and at that point all 128 bytes are final.
- R5: In mode 0 (incrementing), byte i of the packet equals i.
- R6: In mode 1 (random), each byte comes from one step of a 32-bit right-shifting Galois LFSR. The step is: s = s>>1, then XOR with 0x80200003 if the bit shifted out was 1. The byte is the low 8 bits of the new state. The state carries over from one packet to the next. A write to the seed register loads the state with the written value, or with 0xA5A55A5A if the written value is 0.
- R7: A write to address 0x1000+i (i from 0 to 127) stores `reg_wdata[7:0]` in user entry i. A read of that address returns the entry in bits 7:0 with the upper bits 0. In mode 3, byte i of the packet equals entry i.
- R8: A request on an idle generator in mode 2, or in any mode from 4 to 15, sets error bit 0. It starts no packet, and `pkt_ready` and `pkt_data` keep their values.
- R9: A request on an idle, disabled generator sets error bit 1 and starts no packet.
- R10: Any write to the control register clears both error bits. If a request in the same cycle sets a bit, the set wins. Writes to the error register have no effect.
- R11: A request that arrives while a packet is being built is ignored. It does not change the completion cycle, the packet contents or the error register. The mode is captured when a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 32 | Register bus address |
| reg_wdata | input | 32 | Register bus write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| gen_req | input | 1 | Packet request pulse |
| pkt_data | output | 1024 | Packet, byte i at bits 8*i+7:8*i |
| pkt_ready | output | 1 | Packet complete flag |

## Verification
There is one register stage between a bus strobe and its effect. Read data is valid right after the edge that samples the read strobe. Register writes and error updates show up in the cycle after the write edge or the request edge. The bench drives and samples on the falling edge, and reads back each result right after the edge that produced it. For every accepted request, the bench checks that `pkt_ready` is still low after 127 edges past the accepting edge and high after 128. Only then does it compare all 128 bytes against values it computes itself. The ignored-request and disabled cases use the same counted windows, so a packet that finishes early, late, or not at all is caught.

// File: rtl/pg_pkg.sv
// Package: shared constants, mode codes and the LFSR step for the packet generator.
// Assumes a 32-bit register bus and a packet of PKT_BYTES bytes.
package pg_pkg;
    localparam int unsigned BUS_W     = 32;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned PKT_BYTES = 128;
    localparam int unsigned IDX_W     = $clog2(PKT_BYTES);
    localparam int unsigned PKT_W     = PKT_BYTES * BYTE_W;

    localparam logic [BUS_W-1:0] A_CTRL = 32'h0000_0000;
    localparam logic [BUS_W-1:0] A_CFG  = 32'h0000_0001;
    localparam logic [BUS_W-1:0] A_ERR  = 32'h0000_0002;
    localparam logic [BUS_W-1:0] A_SEED = 32'h0000_0003;
    localparam logic [BUS_W-1:0] A_USR  = 32'h0000_1000;
    localparam int unsigned      USR_HI = BUS_W - IDX_W;

    localparam logic [31:0] LFSR_MASK = 32'h8020_0003;
    localparam logic [31:0] SEED_ALT  = 32'hA5A5_5A5A;

    typedef enum logic [3:0] {
        MODE_INC  = 4'd0,
        MODE_RND  = 4'd1,
        MODE_FILE = 4'd2,
        MODE_USR  = 4'd3
    } mode_e;

    // True when the mode code names a supported byte source.
    function automatic logic mode_ok(input logic [3:0] m);
        return (m == MODE_INC) || (m == MODE_RND) || (m == MODE_USR);
    endfunction

    // One right-shifting Galois step.
    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_MASK) : (s >> 1);
    endfunction
endpackage

// File: rtl/pg_lfsr.sv
// Module: seeded pseudo-random byte source.
// Loads on a seed write (a zero seed becomes SEED_ALT) and advances one step
// per byte request. Load has priority over step. Output is the low byte of
// the stepped state, so it is ready in the same cycle as the step.
module pg_lfsr
    import pg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [31:0]       seed,
    input  logic              step,
    output logic [BYTE_W-1:0] rnd_byte
);
    logic [31:0] state_q;
    logic [31:0] stepped;

    // Next state for one step.
    always_comb stepped = lfsr_next(state_q);

    assign rnd_byte = stepped[BYTE_W-1:0];

    // State register: reset, load from the seed, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEED_ALT;
        else if (load)
            state_q <= (seed == '0) ? SEED_ALT : seed;
        else if (step)
            state_q <= stepped;
    end
endmodule

// File: rtl/pg_regfile.sv
// Module: register bank, user byte memory and error flags.
// Holds enable, mode, seed and the two sticky error bits, decodes the trigger
// bit, and returns registered read data. The user memory has one read port
// for the bus and one for the engine. Assumes busy comes from the engine.
module pg_regfile
    import pg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [BUS_W-1:0]  rdata,
    input  logic              gen_req,
    input  logic              busy,
    output logic              req_any,
    output logic              enable,
    output logic [3:0]        mode,
    output logic              seed_load,
    output logic [31:0]       seed,
    input  logic [IDX_W-1:0]  eng_idx,
    output logic [BYTE_W-1:0] eng_byte,
    output logic [1:0]        err
);
    logic [BYTE_W-1:0] usr_mem [PKT_BYTES];
    logic              hit_usr;
    logic              ctrl_wr;
    logic              trig;
    logic [IDX_W-1:0]  bus_idx;

    // Address decode and write strobes.
    always_comb begin
        hit_usr   = (addr[BUS_W-1:IDX_W] == A_USR[BUS_W-1:IDX_W]);
        bus_idx   = addr[IDX_W-1:0];
        ctrl_wr   = wr && (addr == A_CTRL);
        trig      = ctrl_wr && wdata[1];
        seed_load = wr && (addr == A_SEED);
        req_any   = gen_req || trig;
    end

    assign eng_byte = usr_mem[eng_idx];

    // Control, configuration and seed registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            mode   <= 4'd0;
            seed   <= '0;
        end else if (wr) begin
            if (addr == A_CTRL) enable <= wdata[0];
            if (addr == A_CFG)  mode   <= wdata[3:0];
            if (addr == A_SEED) seed   <= wdata;
        end
    end

    // Sticky error bits: a control write clears them, a refused request sets them.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 2'b00;
        else begin
            logic [1:0] e;
            e = ctrl_wr ? 2'b00 : err;
            if (req_any && !busy) begin
                if (!enable)       e[1] = 1'b1;
                if (!mode_ok(mode)) e[0] = 1'b1;
            end
            err <= e;
        end
    end

    // User memory writes: low byte of the write data only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PKT_BYTES; i++) usr_mem[i] <= '0;
        end else if (wr && hit_usr) begin
            usr_mem[bus_idx] <= wdata[BYTE_W-1:0];
        end
    end

    // Registered read data, updated on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd) begin
            if (hit_usr)             rdata <= BUS_W'(usr_mem[bus_idx]);
            else if (addr == A_CTRL) rdata <= BUS_W'(enable);
            else if (addr == A_CFG)  rdata <= BUS_W'(mode);
            else if (addr == A_ERR)  rdata <= BUS_W'(err);
            else if (addr == A_SEED) rdata <= seed;
            else                     rdata <= '0;
        end
    end
endmodule

// File: rtl/pg_engine.sv
// Module: packet build engine.
// Accepts a request when enabled, idle and in a supported mode, latches the
// mode, then writes one byte per cycle for PKT_BYTES cycles. Ready drops on
// the accepting edge and rises on the edge that stores the last byte.
module pg_engine
    import pg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              enable,
    input  logic [3:0]        mode,
    input  logic [BYTE_W-1:0] rnd_byte,
    input  logic [BYTE_W-1:0] usr_byte,
    output logic              rnd_step,
    output logic [IDX_W-1:0]  idx,
    output logic              busy,
    output logic              accept,
    output logic              ready,
    output logic [PKT_W-1:0]  pkt_flat
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_BYTES - 1);

    logic [3:0]        mode_q;
    logic [BYTE_W-1:0] byte_v;
    logic [BYTE_W-1:0] pkt_q [PKT_BYTES];

    // Acceptance and byte source selection.
    always_comb begin
        accept   = req && !busy && enable && mode_ok(mode);
        rnd_step = busy && (mode_q == MODE_RND);
        case (mode_q)
            MODE_INC: byte_v = BYTE_W'(idx);
            MODE_RND: byte_v = rnd_byte;
            default:  byte_v = usr_byte;
        endcase
    end

    // Sequencer: busy flag, byte index, latched mode and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            idx    <= '0;
            mode_q <= MODE_INC;
            ready  <= 1'b0;
        end else if (accept) begin
            busy   <= 1'b1;
            idx    <= '0;
            mode_q <= mode;
            ready  <= 1'b0;
        end else if (busy) begin
            idx <= idx + 1'b1;
            if (idx == LAST) begin
                busy  <= 1'b0;
                ready <= 1'b1;
            end
        end
    end

    // Packet byte store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PKT_BYTES; i++) pkt_q[i] <= '0;
        end else if (busy) begin
            pkt_q[idx] <= byte_v;
        end
    end

    for (genvar g = 0; g < PKT_BYTES; g++) begin : g_flat
        assign pkt_flat[g*BYTE_W +: BYTE_W] = pkt_q[g];
    end
endmodule

// File: rtl/pktgen_top.sv
// Module: top of the register-configured packet data generator.
// Connects the register bank, the LFSR and the build engine. Assumes one
// clock and a synchronous active-low reset.
module pktgen_top
    import pg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         reg_addr,
    input  logic [31:0]         reg_wdata,
    input  logic                reg_wr,
    input  logic                reg_rd,
    output logic [31:0]         reg_rdata,
    input  logic                gen_req,
    output logic [1023:0]       pkt_data,
    output logic                pkt_ready
);
    logic              req_any, enable, seed_load, busy, accept, rnd_step;
    logic [3:0]        mode;
    logic [31:0]       seed;
    logic [1:0]        err;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] usr_byte, rnd_byte;

    pg_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
        .wr(reg_wr), .rd(reg_rd), .rdata(reg_rdata), .gen_req(gen_req),
        .busy(busy), .req_any(req_any), .enable(enable), .mode(mode),
        .seed_load(seed_load), .seed(seed), .eng_idx(idx),
        .eng_byte(usr_byte), .err(err)
    );

    pg_lfsr u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed_load ? reg_wdata : seed),
        .step(rnd_step), .rnd_byte(rnd_byte)
    );

    pg_engine u_eng (
        .clk(clk), .rst_n(rst_n), .req(req_any), .enable(enable), .mode(mode),
        .rnd_byte(rnd_byte), .usr_byte(usr_byte), .rnd_step(rnd_step),
        .idx(idx), .busy(busy), .accept(accept), .ready(pkt_ready),
        .pkt_flat(pkt_data)
    );
endmodule

// File: rtl/pg_chk.sv
// Checker: temporal properties of the packet generator, bound to the top.
module pg_chk
    import pg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      reg_addr,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [31:0]      reg_rdata,
    input logic             req_any,
    input logic             accept,
    input logic             busy,
    input logic [IDX_W-1:0] idx,
    input logic [1:0]       err,
    input logic             pkt_ready
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_BYTES - 1);

    p_ready_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !pkt_ready);

    p_ready_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_ready) |-> ($past(busy) && $past(idx) == LAST && !busy));

    p_busy_req_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && idx != LAST && req_any) |=> (busy && idx == $past(idx) + 1'b1));

    p_err_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(req_any && !busy) && !(reg_wr && reg_addr == A_CTRL)) |=> $stable(err));

    p_trig_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_CTRL) |=> !reg_rdata[1]);
endmodule

bind pktgen_top pg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .req_any(req_any),
    .accept(accept), .busy(busy), .idx(idx), .err(err), .pkt_ready(pkt_ready)
);

// File: tb/tb_pktgen_top.sv
// Bench: drives and samples on the falling edge; expected values computed here.
module tb_pktgen_top;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   reg_addr = '0, reg_wdata = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0, gen_req = 1'b0;
    logic [31:0]   reg_rdata;
    logic [1023:0] pkt_data;
    logic          pkt_ready;
    int            n_chk = 0, n_fail = 0;
    logic [31:0]   model_s;
    logic [7:0]    exp_pkt [128];
    logic [7:0]    usr_model [128];

    always #2 clk = ~clk;

    pktgen_top dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .gen_req(gen_req), .pkt_data(pkt_data), .pkt_ready(pkt_ready)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse_req();
        gen_req = 1'b1;
        @(negedge clk);
        gen_req = 1'b0;
    endtask

    function automatic logic [31:0] stepf(input logic [31:0] s);
        logic [31:0] t;
        t = {1'b0, s[31:1]};
        if (s[0]) t = t ^ 32'h8020_0003;
        return t;
    endfunction

    // Wait from just after the accepting edge; check the ready timing (R4).
    task automatic wait_done(input bit late_req);
        check(pkt_ready == 1'b0, "R4 ready low after accept", 32'(pkt_ready), 0);
        for (int k = 1; k < 128; k++) begin
            if (late_req && k == 10) begin
                gen_req = 1'b1; @(negedge clk); gen_req = 1'b0;
            end else
                @(negedge clk);
        end
        check(pkt_ready == 1'b0, "R4/R11 ready low at edge 127", 32'(pkt_ready), 0);
        @(negedge clk);
        check(pkt_ready == 1'b1, "R4/R11 ready high at edge 128", 32'(pkt_ready), 1);
    endtask

    task automatic cmp_pkt(input string req);
        int bad;
        bad = -1;
        for (int i = 127; i >= 0; i--)
            if (pkt_data[i*8 +: 8] !== exp_pkt[i]) bad = i;
        if (bad < 0) check(1'b1, req, 0, 0);
        else check(1'b0, req, 32'(pkt_data[bad*8 +: 8]), 32'(exp_pkt[bad]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog R4 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [1023:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(pkt_ready == 1'b0, "R1 ready", 32'(pkt_ready), 0);
        check(pkt_data == '0, "R1 pkt zero", pkt_data[31:0], 0);
        for (int a = 0; a < 4; a++) begin
            rd(32'(a), d);
            check(d == 0, "R1 register reset", d, 0);
        end

        // R2 readback and unmapped address
        wr(32'h1, 32'hFFFF_FFF3); rd(32'h1, d);
        check(d == 32'h3, "R2 cfg readback", d, 32'h3);
        wr(32'h3, 32'h1234_5678); model_s = 32'h1234_5678; rd(32'h3, d);
        check(d == 32'h1234_5678, "R2 seed readback", d, 32'h1234_5678);
        rd(32'h4, d);   check(d == 0, "R2 unmapped", d, 0);
        rd(32'h1080, d); check(d == 0, "R2 unmapped above window", d, 0);

        // R9 disabled request
        pulse_req();
        check(pkt_ready == 1'b0, "R9 no packet", 32'(pkt_ready), 0);
        rd(32'h2, d); check(d == 32'h2, "R9 err bit1", d, 2);
        wr(32'h2, 32'h0); rd(32'h2, d);
        check(d == 32'h2, "R10 err write ignored", d, 2);
        wr(32'h0, 32'h1); rd(32'h2, d);
        check(d == 0, "R10 ctrl write clears", d, 0);
        rd(32'h0, d); check(d == 32'h1, "R2 enable readback", d, 1);

        // R7 user memory fill
        for (int i = 0; i < 128; i++) begin
            usr_model[i] = 8'((i * 37 + 5) ^ (i >> 2));
            wr(32'h1000 + 32'(i), {24'hABCDEF, usr_model[i]});
        end
        for (int i = 0; i < 128; i += 17) begin
            rd(32'h1000 + 32'(i), d);
            check(d == 32'(usr_model[i]), "R7 user readback", d, 32'(usr_model[i]));
        end

        // R7 user mode packet
        pulse_req(); wait_done(1'b0);
        for (int i = 0; i < 128; i++) exp_pkt[i] = usr_model[i];
        cmp_pkt("R7 user packet");

        // R5 incrementing via trigger bit (R3), with busy request (R11)
        wr(32'h1, 32'h0);
        wr(32'h0, 32'h3); wait_done(1'b1);
        for (int i = 0; i < 128; i++) exp_pkt[i] = 8'(i);
        cmp_pkt("R5/R3/R11 incrementing packet");
        rd(32'h2, d); check(d == 0, "R11 no error from busy request", d, 0);
        rd(32'h0, d); check(d == 32'h1, "R3 trigger reads zero", d, 1);

        // R6 random, seed 0x12345678 then continuation
        wr(32'h1, 32'h1);
        for (int p = 0; p < 2; p++) begin
            pulse_req(); wait_done(1'b0);
            for (int i = 0; i < 128; i++) begin
                model_s = stepf(model_s); exp_pkt[i] = model_s[7:0];
            end
            cmp_pkt("R6 random packet");
        end
        wr(32'h3, 32'h0); model_s = 32'hA5A5_5A5A;
        pulse_req(); wait_done(1'b0);
        for (int i = 0; i < 128; i++) begin
            model_s = stepf(model_s); exp_pkt[i] = model_s[7:0];
        end
        cmp_pkt("R6 zero seed packet");

        // R8 unsupported modes
        for (int m = 2; m < 16; m++) begin
            if (m == 3) continue;
            snap = pkt_data;
            wr(32'h1, 32'(m));
            pulse_req();
            @(negedge clk);
            check(pkt_ready == 1'b1 && pkt_data == snap, "R8 no packet", 32'(m), 32'(m));
            rd(32'h2, d); check(d == 32'h1, "R8 err bit0", d, 1);
            wr(32'h0, 32'h1);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule